// File: doc/BRIEF.md
# Auxiliary Feature Control Register

This block holds a 32-bit privileged configuration word on a coprocessor register-access port. The port carries separate read and write strobes, a privilege flag and a secure-world flag. The block stores the word and applies the access rules for each mode and world. Secure privileged code may read and write the word. Non-secure privileged code may only read it. Any user-mode access raises an undefined-instruction trap.

The block also combines the stored bits with three inputs from the main control register: the flow-prediction enable, the fast-interrupt enable and the random cache-replacement select. From these it produces the effective enables for the pipeline and memory system. These cover the branch predictors, the return stack, branch folding, the fast interrupt response, hit-under-miss, precise load aborts, the MicroTLB replacement policy, the cache-size limit, block cache operations, clean-entire-data-cache, prefetch halting and forced speculative PC updates. All of these enables are combinational from the stored word and the external inputs.

Top module: `aux_ctrl_unit`

## Requirements
- R1: After reset the word reads as 0x00000007, so bits 2:0 are 1 and every other bit is 0.
- R2: Bit 2 drives static prediction, bit 1 drives dynamic prediction and bit 0 drives the return stack. Each is active only while `flowPredEn` is 1.
- R3: `tlbRandomRepl` is 1 only when bit 3 is 1 and `cacheRandRepl` is 1. Otherwise the MicroTLB uses round robin.
- R4: Bit 31 set forces `fastIrqOn` low whatever the value of `fastIrqEn`. It also forces `hitUnderMissOn` low and `preciseLoadAbort` high. With bit 31 clear, `fastIrqOn` follows `fastIrqEn`, `hitUnderMissOn` is 1 and `preciseLoadAbort` is 0.
- R5: `foldOn` is 1 only when bit 29 is 0 and at least one of static or dynamic prediction is active.
- R6: Bit 6 set drives `cacheLimit16k` high. Each of the following outputs is 1 while its bit is 0: bit 5 drives `blockCacheOpsOn`, bit 4 drives `cleanAllOn`, bit 28 drives `prefetchHaltOn` and bit 30 drives `forcedSpecOn`.
- R7: Bits 27:7 always read as 0, and writes to them are ignored.
- R8: A secure privileged write (`accWr`, `accPriv` and `accSecure` all 1) loads `wrData` into the word at the next rising clock edge. A privileged read raises `rdValid` and returns the word on `rdData` in the same cycle.
- R9: A non-secure privileged read returns the word. A non-secure privileged write leaves the word unchanged and raises no trap.
- R10: A user-mode access (`accPriv` 0 with `accRd` or `accWr` 1) raises `undefTrap` in the same cycle. It keeps `rdValid` low and `rdData` at 0, and it leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accRd | input | 1 | Read strobe |
| accWr | input | 1 | Write strobe |
| accPriv | input | 1 | 1 = privileged access |
| accSecure | input | 1 | 1 = secure world |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, 0 when no valid read |
| rdValid | output | 1 | Read accepted this cycle |
| undefTrap | output | 1 | Undefined-instruction trap |
| flowPredEn | input | 1 | Flow-prediction enable from main control |
| fastIrqEn | input | 1 | Fast-interrupt enable from main control |
| cacheRandRepl | input | 1 | Cache uses random replacement |
| staticPredOn | output | 1 | Static prediction active |
| dynPredOn | output | 1 | Dynamic prediction active |
| retStackOn | output | 1 | Return stack active |
| foldOn | output | 1 | Branch folding active |
| fastIrqOn | output | 1 | Fast interrupt response active |
| hitUnderMissOn | output | 1 | Hit-under-miss active |
| preciseLoadAbort | output | 1 | External load aborts precise |
| tlbRandomRepl | output | 1 | MicroTLB random replacement |
| cacheLimit16k | output | 1 | Cache limited to 16KB |
| blockCacheOpsOn | output | 1 | Block cache operations allowed |
| cleanAllOn | output | 1 | Clean-entire-data-cache allowed |
| prefetchHaltOn | output | 1 | Prefetch halting active |
| forcedSpecOn | output | 1 | Forced speculative PC updates allowed |

## Verification
The hardest situation to reach is a word that differs from its current value, followed by a write that should be ignored, and that situation has to be visible at the ports. Neither a non-secure write nor a user write may change the word. The word is also biased by its reset value, so a dropped write can look correct by chance. The stimulus therefore first loads a distinct pattern with a secure privileged write. It then issues the forbidden writes with the inverted data and reads the word back. Random cycles interleave writes from every mode and world with changing external enables. These cycles reach the gating combinations where bit 31 overrides the fast-interrupt enable and where folding depends on predictors that flow-prediction gating has turned off.

// File: rtl/aux_ctrl_pkg.sv
package aux_ctrl_pkg;
  localparam int CFG_W = 32;

  // bit positions that decide behaviour
  localparam int B_RETSTK  = 0;
  localparam int B_DYNPRED = 1;
  localparam int B_STATPRED = 2;
  localparam int B_TLBRAND = 3;
  localparam int B_NOCLEAN = 4;
  localparam int B_NOBLOCK = 5;
  localparam int B_LIM16K  = 6;
  localparam int B_NOPFHALT = 28;
  localparam int B_NOFOLD  = 29;
  localparam int B_NOSPEC  = 30;
  localparam int B_IRQOVR  = 31;

  localparam logic [CFG_W-1:0] IMPL_MASK = 32'hF000_007F;
  localparam logic [CFG_W-1:0] RESET_VAL = 32'h0000_0007;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic trap;
  } accStrobe_t;

  typedef struct packed {
    logic staticPred;
    logic dynPred;
    logic retStack;
    logic fold;
    logic fastIrq;
    logic hitUnderMiss;
    logic preciseAbort;
    logic tlbRandom;
    logic limit16k;
    logic blockOps;
    logic cleanAll;
    logic pfHalt;
    logic forcedSpec;
  } featEn_t;
endpackage

// File: rtl/aux_ctrl_access.sv
module aux_ctrl_access
  import aux_ctrl_pkg::*;
(
  input  logic       accRd,
  input  logic       accWr,
  input  logic       accPriv,
  input  logic       accSecure,
  output accStrobe_t strb
);
  logic anyAccess;
  logic writeAllowed;

  always_comb begin
    anyAccess    = accRd | accWr;
    // only the secure world may modify; non-secure writes are dropped quietly
    writeAllowed = accPriv & accSecure;
    strb.rdEn    = accRd & accPriv;
    strb.wrEn    = accWr & writeAllowed;
    strb.trap    = anyAccess & ~accPriv;
  end
endmodule

// File: rtl/aux_ctrl_datapath.sv
module aux_ctrl_datapath
  import aux_ctrl_pkg::*;
#(
  parameter int                 W        = CFG_W,
  parameter logic [CFG_W-1:0]   MASK     = IMPL_MASK,
  parameter logic [CFG_W-1:0]   RST_WORD = RESET_VAL
) (
  input  logic         clk,
  input  logic         rstN,
  input  accStrobe_t   strb,
  input  logic [W-1:0] wrData,
  input  logic         flowPredEn,
  input  logic         fastIrqEn,
  input  logic         cacheRandRepl,
  output logic [W-1:0] cfgQ,
  output logic [W-1:0] rdData,
  output featEn_t      feat
);
  localparam logic [W-1:0] RST_MASKED = RST_WORD[W-1:0] & MASK[W-1:0];

  logic [W-1:0] cfgNext;

  always_comb begin
    cfgNext = wrData & MASK[W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cfgQ <= RST_MASKED;
    else if (strb.wrEn) cfgQ <= cfgNext;
  end

  // read return, one gate per bit
  for (genvar i = 0; i < W; i++) begin : g_rd
    if (MASK[i]) begin : g_impl
      assign rdData[i] = strb.rdEn & cfgQ[i];
    end else begin : g_tie
      assign rdData[i] = 1'b0;
    end
  end

  logic predAny;

  always_comb begin
    feat.staticPred   = cfgQ[B_STATPRED] & flowPredEn;
    feat.dynPred      = cfgQ[B_DYNPRED]  & flowPredEn;
    feat.retStack     = cfgQ[B_RETSTK]   & flowPredEn;
    predAny           = feat.staticPred | feat.dynPred;
    feat.fold         = ~cfgQ[B_NOFOLD] & predAny;
    feat.fastIrq      = fastIrqEn & ~cfgQ[B_IRQOVR];
    feat.hitUnderMiss = ~cfgQ[B_IRQOVR];
    feat.preciseAbort = cfgQ[B_IRQOVR];
    feat.tlbRandom    = cfgQ[B_TLBRAND] & cacheRandRepl;
    feat.limit16k     = cfgQ[B_LIM16K];
    feat.blockOps     = ~cfgQ[B_NOBLOCK];
    feat.cleanAll     = ~cfgQ[B_NOCLEAN];
    feat.pfHalt       = ~cfgQ[B_NOPFHALT];
    feat.forcedSpec   = ~cfgQ[B_NOSPEC];
  end
endmodule

// File: rtl/aux_ctrl_unit.sv
module aux_ctrl_unit
  import aux_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        accRd,
  input  logic        accWr,
  input  logic        accPriv,
  input  logic        accSecure,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        rdValid,
  output logic        undefTrap,
  input  logic        flowPredEn,
  input  logic        fastIrqEn,
  input  logic        cacheRandRepl,
  output logic        staticPredOn,
  output logic        dynPredOn,
  output logic        retStackOn,
  output logic        foldOn,
  output logic        fastIrqOn,
  output logic        hitUnderMissOn,
  output logic        preciseLoadAbort,
  output logic        tlbRandomRepl,
  output logic        cacheLimit16k,
  output logic        blockCacheOpsOn,
  output logic        cleanAllOn,
  output logic        prefetchHaltOn,
  output logic        forcedSpecOn
);
  accStrobe_t        strb;
  featEn_t           feat;
  logic [CFG_W-1:0]  cfgQ;

  aux_ctrl_access u_access (
    .accRd     (accRd),
    .accWr     (accWr),
    .accPriv   (accPriv),
    .accSecure (accSecure),
    .strb      (strb)
  );

  aux_ctrl_datapath u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .wrData        (wrData),
    .flowPredEn    (flowPredEn),
    .fastIrqEn     (fastIrqEn),
    .cacheRandRepl (cacheRandRepl),
    .cfgQ          (cfgQ),
    .rdData        (rdData),
    .feat          (feat)
  );

  assign rdValid          = strb.rdEn;
  assign undefTrap        = strb.trap;
  assign staticPredOn     = feat.staticPred;
  assign dynPredOn        = feat.dynPred;
  assign retStackOn       = feat.retStack;
  assign foldOn           = feat.fold;
  assign fastIrqOn        = feat.fastIrq;
  assign hitUnderMissOn   = feat.hitUnderMiss;
  assign preciseLoadAbort = feat.preciseAbort;
  assign tlbRandomRepl    = feat.tlbRandom;
  assign cacheLimit16k    = feat.limit16k;
  assign blockCacheOpsOn  = feat.blockOps;
  assign cleanAllOn       = feat.cleanAll;
  assign prefetchHaltOn   = feat.pfHalt;
  assign forcedSpecOn     = feat.forcedSpec;
endmodule

// File: rtl/aux_ctrl_checker.sv
module aux_ctrl_checker
  import aux_ctrl_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        accWr,
  input logic        accPriv,
  input logic        accSecure,
  input logic [31:0] wrData,
  input logic [31:0] cfgQ,
  input logic        rdValid,
  input logic        undefTrap,
  input logic        flowPredEn,
  input logic        cacheRandRepl,
  input logic        staticPredOn,
  input logic        dynPredOn,
  input logic        retStackOn,
  input logic        foldOn,
  input logic        fastIrqOn,
  input logic        hitUnderMissOn,
  input logic        tlbRandomRepl
);
  a_r8_secure_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    accWr && accPriv && accSecure |=> cfgQ == ($past(wrData) & IMPL_MASK));

  a_r9_ns_write_dropped: assert property (@(posedge clk) disable iff (!rstN)
    accWr && accPriv && !accSecure |=> $stable(cfgQ));

  a_r10_user_write_dropped: assert property (@(posedge clk) disable iff (!rstN)
    accWr && !accPriv |=> $stable(cfgQ));

  a_r10_trap_no_data: assert property (@(posedge clk) disable iff (!rstN)
    undefTrap |-> !rdValid);

  a_r7_unimpl_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ & ~IMPL_MASK) == 32'h0);

  a_r2_pred_gated: assert property (@(posedge clk) disable iff (!rstN)
    !flowPredEn |-> !staticPredOn && !dynPredOn && !retStackOn);

  a_r4_override: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ[B_IRQOVR] |-> !fastIrqOn && !hitUnderMissOn);

  a_r5_fold_needs_pred: assert property (@(posedge clk) disable iff (!rstN)
    foldOn |-> staticPredOn || dynPredOn);

  a_r3_tlb_needs_cache: assert property (@(posedge clk) disable iff (!rstN)
    tlbRandomRepl |-> cacheRandRepl);
endmodule

bind aux_ctrl_unit aux_ctrl_checker u_chk (.*);

// File: tb/sim_aux_ctrl_unit.sv
`timescale 1ns/1ps
module sim_aux_ctrl_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accRd = 1'b0, accWr = 1'b0, accPriv = 1'b0, accSecure = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        rdValid, undefTrap;
  logic        flowPredEn = 1'b1, fastIrqEn = 1'b0, cacheRandRepl = 1'b0;
  logic        staticPredOn, dynPredOn, retStackOn, foldOn, fastIrqOn, hitUnderMissOn;
  logic        preciseLoadAbort, tlbRandomRepl, cacheLimit16k, blockCacheOpsOn;
  logic        cleanAllOn, prefetchHaltOn, forcedSpecOn;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model;

  always #5 clk = ~clk;

  aux_ctrl_unit u0 (.*);

  function automatic logic [12:0] expFeat(logic [31:0] w, logic z, logic fi, logic rr);
    logic s, d;
    s = w[2] & z;
    d = w[1] & z;
    return {~w[30], ~w[28], ~w[4], ~w[5], w[6], w[31], ~w[31], fi & ~w[31],
            w[3] & rr, ~w[29] & (s | d), w[0] & z, d, s};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkFeat();
    logic [12:0] a, e;
    a = {forcedSpecOn, prefetchHaltOn, cleanAllOn, blockCacheOpsOn, cacheLimit16k,
         preciseLoadAbort, hitUnderMissOn, fastIrqOn, tlbRandomRepl, foldOn,
         retStackOn, dynPredOn, staticPredOn};
    e = expFeat(model, flowPredEn, fastIrqEn, cacheRandRepl);
    chk("R2 predictors", {29'd0, a[2:0]}, {29'd0, e[2:0]});
    chk("R5 folding", {31'd0, a[3]}, {31'd0, e[3]});
    chk("R3 tlb policy", {31'd0, a[4]}, {31'd0, e[4]});
    chk("R4 irq override", {29'd0, a[7:5]}, {29'd0, e[7:5]});
    chk("R6 disables", {27'd0, a[12:8]}, {27'd0, e[12:8]});
  endtask

  task automatic doWrite(logic [31:0] d, logic p, logic s);
    @(negedge clk);
    accWr = 1'b1; accPriv = p; accSecure = s; wrData = d;
    #1;
    chk(p ? "R9 no trap on priv write" : "R10 user write trap", {31'd0, undefTrap}, {31'd0, ~p});
    @(posedge clk);
    if (p && s) model = d & 32'hF000_007F;
    @(negedge clk);
    accWr = 1'b0; accPriv = 1'b0; accSecure = 1'b0;
    #1;
    checkFeat();
  endtask

  task automatic doRead(logic p, logic s, string tag);
    @(negedge clk);
    accRd = 1'b1; accPriv = p; accSecure = s;
    #1;
    chk(tag, rdData, p ? model : 32'h0);
    chk(tag, {30'd0, rdValid, undefTrap}, {30'd0, p, ~p});
    accRd = 1'b0; accPriv = 1'b0; accSecure = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model = 32'h0000_0007;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R1 reset value
    doRead(1'b1, 1'b1, "R1 reset word");
    checkFeat();
    // R8 secure write then read; R7 unimplemented bits masked
    doWrite(32'hFFFF_FFFF, 1'b1, 1'b1);
    doRead(1'b1, 1'b1, "R7 unimpl bits read zero");
    doWrite(32'h5000_0035, 1'b1, 1'b1);
    doRead(1'b1, 1'b1, "R8 secure readback");
    // R9 non-secure: readable, write dropped
    doWrite(32'hAFFF_FFCA, 1'b1, 1'b0);
    doRead(1'b1, 1'b0, "R9 ns write dropped");
    // R10 user access traps and changes nothing
    doWrite(32'hAFFF_FFCA, 1'b0, 1'b1);
    doRead(1'b0, 1'b1, "R10 user read trap");
    doRead(1'b1, 1'b1, "R10 word unchanged");
    // R2/R5 flow prediction off kills predictors and folding
    doWrite(32'h0000_0007, 1'b1, 1'b1);
    flowPredEn = 1'b0; #1; checkFeat();
    // R3 tlb random needs cache random
    doWrite(32'h0000_0008, 1'b1, 1'b1);
    cacheRandRepl = 1'b0; #1; checkFeat();
    cacheRandRepl = 1'b1; #1; checkFeat();
    // R4 override beats fast-interrupt enable
    fastIrqEn = 1'b1;
    doWrite(32'h8000_0000, 1'b1, 1'b1);
    doWrite(32'h0000_0000, 1'b1, 1'b1);
    // random mix
    for (int i = 0; i < 400; i++) begin
      flowPredEn    = $urandom_range(0, 1);
      fastIrqEn     = $urandom_range(0, 1);
      cacheRandRepl = $urandom_range(0, 1);
      if ($urandom_range(0, 2) != 0)
        doWrite($urandom, $urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0);
      else
        doRead($urandom_range(0, 3) != 0, $urandom_range(0, 1), "R8 random read");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule